// File: doc/BRIEF.md
# Masked Time-Match Alarm Interrupt

This block watches a running BCD time of day (seconds, minutes, hours, day of month) and raises an alarm when it matches four programmable alarm registers. Each alarm register carries a "don't care" bit in its most significant position. Together the four bits pick how often the alarm repeats: every second, or on a match of seconds, of minutes and seconds, of hours, minutes and seconds, or of the full date and time. A match sets a sticky alarm flag. When enabled, the match also pulls an active-low interrupt line, modelled as a registered level.

The flag is visible in a flags register on a small synchronous register bus. Any access to that register lets the interrupt go as soon as the access is seen. The flag itself is cleared only once the access has finished. A separate enable decides whether alarms may interrupt while the system runs from its backup supply.

The same interrupt line doubles as a frequency-test output. It toggles on every tick of a 1024 Hz strobe, which gives a 512 Hz square wave, when the test is permitted. The current time, the one-second strobe, the 1024 Hz strobe, the backup-mode indicator and two watchdog status bits all come from neighbouring blocks.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is 1. Register index map: 0 holds the flags, with the alarm flag in bit 6 (read only). Indices 1, 2, 3 and 4 hold the seconds, minutes, hours and date alarms, each with its mask bit in bit 7. Index 5 is the control register: bit 7 alarm enable, bit 6 backup alarm enable, bit 0 frequency test. Read data is registered and appears one cycle after a read access is presented.
- R2: The mask bits, taken as {date, hours, minutes, seconds}, select the alarm rate as follows. 1111 gives every second. 1110 fires on a seconds match. 1100 fires on a minutes and seconds match. 1000 fires on an hours, minutes and seconds match. 0000 fires on a date, hours, minutes and seconds match. Seconds and minutes compare bits 6:0, and hours and date compare bits 5:0. The mask bit never takes part in the comparison.
- R3: Any other mask pattern fires on every `sec_tick`.
- R4: A match is evaluated only in a cycle with `sec_tick` high. It sets the alarm flag at that clock edge whatever the enables are set to. Without a tick, the flag is never set.
- R5: While `on_battery` is 0, `irq_n` goes low at the same edge the flag is set, provided alarm enable is 1. It stays low until the flag is cleared or a flags access is in progress.
- R6: During any read or write of the flags register, `irq_n` is 1 from the first edge of the access. The alarm flag stays set until the edge after the access ends, and then reads 0. `irq_n` does not fall again when the access ends.
- R7: While `on_battery` is 1, an alarm drives `irq_n` low only if both alarm enable and backup alarm enable are 1.
- R8: When the frequency-test bit is 1, alarm enable is 0, and either `wdog_steer` or `wdog_idle` is 1, `irq_n` inverts on every `ft_tick`. The first tick drives it low.
- R9: The frequency test is suppressed when alarm enable is 1, or when both watchdog inputs are 0. `irq_n` then ignores `ft_tick` and sits at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sec_tick | input | 1 | One-cycle strobe each second; time inputs valid with it |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24 h |
| cur_date | input | 8 | Current day of month, BCD |
| ft_tick | input | 1 | One-cycle strobe at 1024 Hz for the frequency test |
| on_battery | input | 1 | System is running from the backup supply |
| wdog_steer | input | 1 | Watchdog routes its timeout to the reset line |
| wdog_idle | input | 1 | Watchdog register is all zero |
| bus_cs | input | 1 | Register access active (held for the whole access) |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt / frequency-test level |

## Verification
The alarm flag and `irq_n` both change at the edge that samples `sec_tick`, so the bench checks them at the falling edge that follows. The frequency-test output also moves at the edge that samples `ft_tick`. Read data is registered, so the bench samples it at the falling edge after the access is presented. For the flags-register split, `irq_n` is checked high at the first falling edge inside the access. The flag is read back only after the edge that follows the deassertion of `bus_cs`, and `irq_n` is checked at every falling edge in between.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_ALM = 4;

  // register indices on the bus
  localparam int IDX_FLAGS = 0;
  localparam int IDX_SEC   = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 3;
  localparam int IDX_DATE  = 4;
  localparam int IDX_CTRL  = 5;

  // control bit positions
  localparam int CTRL_AE  = 7;
  localparam int CTRL_ABE = 6;
  localparam int CTRL_FT  = 0;
  localparam int FLAG_AF  = 6;

  typedef enum logic [2:0] {
    RATE_EVERY,
    RATE_SEC,
    RATE_MIN,
    RATE_HOUR,
    RATE_DATE
  } rate_e;

  typedef struct packed {
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } tod_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              af_q,
  output tod_t              alm,
  output logic              ae,
  output logic              abe,
  output logic              ft_en,
  output logic              flag_hit,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] alm_r [NUM_ALM];
  logic [DATA_W-1:0] ctrl_r;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_en;

  assign wr_en    = bus_cs && bus_we;
  assign flag_hit = bus_cs && (bus_addr == ADDR_W'(IDX_FLAGS));

  // one holding register per alarm field, indices IDX_SEC..IDX_DATE
  for (genvar gi = 0; gi < NUM_ALM; gi++) begin : g_alm
    always_ff @(posedge clk) begin
      if (rst) begin
        alm_r[gi] <= '0;
      end else if (wr_en && bus_addr == ADDR_W'(IDX_SEC + gi)) begin
        alm_r[gi] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r <= '0;
    end else if (wr_en && bus_addr == ADDR_W'(IDX_CTRL)) begin
      ctrl_r <= bus_wdata & DATA_W'((1 << CTRL_AE) | (1 << CTRL_ABE) | (1 << CTRL_FT));
    end
  end

  assign alm.sec  = alm_r[0];
  assign alm.min  = alm_r[1];
  assign alm.hour = alm_r[2];
  assign alm.date = alm_r[3];
  assign ae       = ctrl_r[CTRL_AE];
  assign abe      = ctrl_r[CTRL_ABE];
  assign ft_en    = ctrl_r[CTRL_FT];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(IDX_FLAGS)) begin
      rd_mux[FLAG_AF] = af_q;
    end else if (bus_addr == ADDR_W'(IDX_CTRL)) begin
      rd_mux = ctrl_r;
    end else begin
      for (int i = 0; i < NUM_ALM; i++) begin
        if (bus_addr == ADDR_W'(IDX_SEC + i)) rd_mux = alm_r[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_cs && !bus_we) begin
      rdata_q <= rd_mux;
    end else begin
      rdata_q <= '0;
    end
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int LO_W = 7,
  parameter int HI_W = 6
) (
  input  logic sec_tick,
  input  tod_t cur,
  input  tod_t alm,
  output logic hit
);
  localparam int MSK = BYTE_W - 1;

  logic [3:0] mask;
  rate_e      rate;
  logic       eq_s, eq_m, eq_h, eq_d;
  logic       match;

  assign mask = {alm.date[MSK], alm.hour[MSK], alm.min[MSK], alm.sec[MSK]};

  // value bits only; the mask bit is excluded
  assign eq_s = alm.sec[LO_W-1:0]  == cur.sec[LO_W-1:0];
  assign eq_m = alm.min[LO_W-1:0]  == cur.min[LO_W-1:0];
  assign eq_h = alm.hour[HI_W-1:0] == cur.hour[HI_W-1:0];
  assign eq_d = alm.date[HI_W-1:0] == cur.date[HI_W-1:0];

  always_comb begin
    case (mask)
      4'b1110: rate = RATE_SEC;
      4'b1100: rate = RATE_MIN;
      4'b1000: rate = RATE_HOUR;
      4'b0000: rate = RATE_DATE;
      default: rate = RATE_EVERY;
    endcase
  end

  always_comb begin
    case (rate)
      RATE_SEC:  match = eq_s;
      RATE_MIN:  match = eq_s && eq_m;
      RATE_HOUR: match = eq_s && eq_m && eq_h;
      RATE_DATE: match = eq_s && eq_m && eq_h && eq_d;
      default:   match = 1'b1;
    endcase
  end

  assign hit = sec_tick && match;
endmodule

// File: rtl/alarm_irq_ctl.sv
module alarm_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic flag_hit,
  input  logic ae,
  input  logic abe,
  input  logic ft_en,
  input  logic on_battery,
  input  logic wdog_steer,
  input  logic wdog_idle,
  input  logic ft_tick,
  output logic af_q,
  output logic irq_n_q
);
  logic flag_acc_q;
  logic acc_end;
  logic af_d;
  logic ae_eff;
  logic ft_act;
  logic ft_ph_q, ft_ph_d;
  logic irq_n_d;

  assign ae_eff  = on_battery ? (ae && abe) : ae;
  assign acc_end = flag_acc_q && !flag_hit;
  assign af_d    = hit ? 1'b1 : (acc_end ? 1'b0 : af_q);
  assign ft_act  = ft_en && !ae && (wdog_steer || wdog_idle);
  assign ft_ph_d = !ft_act ? 1'b0 : (ft_tick ? !ft_ph_q : ft_ph_q);
  assign irq_n_d = ft_act ? !ft_ph_d : !(af_d && ae_eff && !flag_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_acc_q <= 1'b0;
      af_q       <= 1'b0;
      ft_ph_q    <= 1'b0;
      irq_n_q    <= 1'b1;
    end else begin
      flag_acc_q <= flag_hit;
      af_q       <= af_d;
      ft_ph_q    <= ft_ph_d;
      irq_n_q    <= irq_n_d;
    end
  end

  // R5
  alarm_drv_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_q && !$past(ft_act)) |-> af_q);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flag_hit && !ft_act) |-> irq_n_q);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hit) |-> af_q);

  // R4
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(af_q) |-> $past(hit));

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(af_q) |-> $past(flag_acc_q && !flag_hit));

  // R7
  batt_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_q && $past(on_battery && !ft_act)) |-> $past(abe));
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [DATA_W-1:0] cur_sec,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [DATA_W-1:0] cur_date,
  input  logic              ft_tick,
  input  logic              on_battery,
  input  logic              wdog_steer,
  input  logic              wdog_idle,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  tod_t cur;
  tod_t alm;
  logic ae, abe, ft_en, flag_hit, hit, af_q;

  assign cur.sec  = cur_sec;
  assign cur.min  = cur_min;
  assign cur.hour = cur_hour;
  assign cur.date = cur_date;

  alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_cs   (bus_cs),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .af_q     (af_q),
    .alm      (alm),
    .ae       (ae),
    .abe      (abe),
    .ft_en    (ft_en),
    .flag_hit (flag_hit),
    .rdata_q  (bus_rdata)
  );

  alarm_cmp u_cmp (
    .sec_tick(sec_tick),
    .cur     (cur),
    .alm     (alm),
    .hit     (hit)
  );

  alarm_irq_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .flag_hit  (flag_hit),
    .ae        (ae),
    .abe       (abe),
    .ft_en     (ft_en),
    .on_battery(on_battery),
    .wdog_steer(wdog_steer),
    .wdog_idle (wdog_idle),
    .ft_tick   (ft_tick),
    .af_q      (af_q),
    .irq_n_q   (irq_n)
  );
endmodule

// File: tb/tb_alarm_match_irq.sv
module tb_alarm_match_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0, ft_tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       on_battery = 1'b0, wdog_steer = 1'b0, wdog_idle = 1'b0;
  logic       bus_cs = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_n;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alarm_match_irq dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .ft_tick(ft_tick), .on_battery(on_battery), .wdog_steer(wdog_steer),
    .wdog_idle(wdog_idle), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // {mask d,h,m,s ; sec ; min ; hour ; date ; expected flag}
  localparam logic [36:0] VEC [12] = '{
    {4'b1111, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    {4'b1110, 8'h30, 8'h00, 8'h00, 8'h00, 1'b1},
    {4'b1110, 8'h31, 8'h15, 8'h08, 8'h21, 1'b0},
    {4'b1100, 8'h30, 8'h15, 8'h00, 8'h00, 1'b1},
    {4'b1100, 8'h30, 8'h14, 8'h08, 8'h21, 1'b0},
    {4'b1000, 8'h30, 8'h15, 8'h08, 8'h00, 1'b1},
    {4'b1000, 8'h30, 8'h15, 8'h09, 8'h21, 1'b0},
    {4'b0000, 8'h30, 8'h15, 8'h08, 8'h21, 1'b1},
    {4'b0000, 8'h30, 8'h15, 8'h08, 8'h22, 1'b0},
    {4'b0101, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    {4'b0011, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    {4'b1101, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_cs = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic ftick();
    @(negedge clk);
    ft_tick = 1'b1;
    @(negedge clk);
    ft_tick = 1'b0;
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd(3'd0, d);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_n at reset", {7'b0, irq_n}, 8'h01);
    rd(3'd0, d); check("R1 flags reset", d, 8'h00);
    rd(3'd5, d); check("R1 ctrl reset", d, 8'h00);
    rd(3'd1, d); check("R1 sec alarm reset", d, 8'h00);

    // R2 / R3 vector table (enables off)
    foreach (VEC[i]) begin
      logic [36:0] v;
      logic [3:0]  m;
      v = VEC[i];
      m = v[36:33];
      wr(3'd1, {m[0], 7'h30});
      wr(3'd2, {m[1], 7'h15});
      wr(3'd3, {m[2], 7'h08});
      wr(3'd4, {m[3], 7'h21});
      cur_sec = v[32:25]; cur_min = v[24:17]; cur_hour = v[16:9]; cur_date = v[8:1];
      clear_flag();
      tick();
      rd(3'd0, d);
      if (m == 4'b1111 || m == 4'b1110 || m == 4'b1100 || m == 4'b1000 || m == 4'b0000)
        check($sformatf("R2 vector %0d", i), d, {1'b0, v[0], 6'b0});
      else
        check($sformatf("R3 vector %0d", i), d, {1'b0, v[0], 6'b0});
    end

    // R4 flag set with enables off, no interrupt; no tick means no flag
    wr(3'd1, 8'hB0); wr(3'd2, 8'h95); wr(3'd3, 8'h88); wr(3'd4, 8'hA1);
    clear_flag();
    tick();
    check("R4 irq stays high with enables off", {7'b0, irq_n}, 8'h01);
    rd(3'd0, d); check("R4 flag set with enables off", d, 8'h40);
    @(negedge clk);
    repeat (5) @(negedge clk);
    rd(3'd0, d); check("R4 no flag without tick", d, 8'h00);

    // R5 interrupt on mains with enable
    @(negedge clk);
    wr(3'd5, 8'h80);
    tick();
    check("R5 irq low on match", {7'b0, irq_n}, 8'h00);

    // R6 split release: hold a flags read for three cycles
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
    @(negedge clk);
    check("R6 irq released in access", {7'b0, irq_n}, 8'h01);
    check("R6 flag still set in access", bus_rdata, 8'h40);
    @(negedge clk);
    check("R6 irq high mid access", {7'b0, irq_n}, 8'h01);
    bus_cs = 1'b0;
    @(negedge clk);
    check("R6 irq high after access", {7'b0, irq_n}, 8'h01);
    rd(3'd0, d); check("R6 flag cleared after access", d, 8'h00);
    @(negedge clk);

    // R7 backup mode needs both enables
    on_battery = 1'b1;
    tick();
    check("R7 ae only on battery", {7'b0, irq_n}, 8'h01);
    rd(3'd0, d); check("R7 flag set on battery", d, 8'h40);
    @(negedge clk);
    wr(3'd5, 8'hC0);
    tick();
    check("R7 ae and abe on battery", {7'b0, irq_n}, 8'h00);
    clear_flag();
    on_battery = 1'b0;

    // R8 frequency test
    wr(3'd5, 8'h01);
    wdog_steer = 1'b1;
    @(negedge clk);
    check("R8 ft idle level", {7'b0, irq_n}, 8'h01);
    ftick();
    check("R8 ft first toggle", {7'b0, irq_n}, 8'h00);
    ftick();
    check("R8 ft second toggle", {7'b0, irq_n}, 8'h01);
    wdog_steer = 1'b0; wdog_idle = 1'b1;
    ftick();
    check("R8 ft with idle watchdog", {7'b0, irq_n}, 8'h00);

    // R9 suppression
    wdog_idle = 1'b0;
    @(negedge clk);
    check("R9 ft off when watchdog busy", {7'b0, irq_n}, 8'h01);
    ftick();
    check("R9 ft tick ignored", {7'b0, irq_n}, 8'h01);
    wdog_steer = 1'b1;
    wr(3'd5, 8'h81);
    ftick();
    check("R9 ft denied by alarm enable", {7'b0, irq_n}, 8'h01);
    rd(3'd5, d); check("R1 ctrl readback", d, 8'h81);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule